// File: doc/BRIEF.md
# Serial Storage Link Out-of-Band Host Initializer

This block runs the host side of the out-of-band wake-up exchange on a serial storage link. While the link is down, it drives a single transmit command. When the command is high, the transmitter sends ALIGN bursts. When it is low, the transmitter holds its lines at electrical idle. The block also receives one-cycle indications from an external squelch detector, which reports that the device's COMINIT or COMWAKE pattern was seen. Each outgoing signal is six bursts, and each burst is followed by an idle gap. Only the timing of bursts and gaps matters: the host's reset signal uses a long gap and its wake signal a short one. All lengths are counted in clock cycles and set by parameters.

After reset the sequencer sends a reset signal and then listens for the device's COMINIT. If COMINIT does not arrive within a retry interval, it sends the reset signal again. If COMINIT arrives, the sequencer sends a wake signal and then waits a bounded time for the device's COMWAKE. If COMWAKE arrives in time, the ready output rises and normal traffic may start. If it does not, the whole exchange starts again from the reset signal. A loss-of-signal input sends the sequencer back to the start from any later phase.

Top module: `oob_host_init`

## Requirements
- R1: While reset is asserted, phase_o reads 0 (sending the reset signal) and ready_o is low. The phase codes are 0 for sending the reset signal, 1 for waiting for COMINIT, 2 for sending the wake signal, 3 for waiting for COMWAKE and 4 for ready.
- R2: In phase 0, tx_burst_o is high for BURST_CYC cycles and then low for RESET_GAP_CYC cycles. This repeats NUM_BURSTS times, starting in the first cycle after reset is released.
- R3: After the last reset gap, the phase becomes 1 and tx_burst_o stays low for the whole of phase 1.
- R4: If no COMINIT arrives within RETRY_CYC cycles of phase 1, the phase returns to 0 and the full reset pattern is sent again.
- R5: A COMINIT pulse during phase 1 moves the phase to 2 at the next edge. Phase 2 then sends NUM_BURSTS bursts of BURST_CYC cycles, each followed by WAKE_GAP_CYC idle cycles, and then enters phase 3.
- R6: COMINIT and COMWAKE pulses that arrive outside the phase that waits for them leave the phase and tx_burst_o unchanged.
- R7: A COMWAKE pulse during phase 3 moves the phase to 4 at the next edge. ready_o is high exactly when the phase is 4.
- R8: If no COMWAKE arrives within WAKE_TO_CYC cycles of phase 3, the phase returns to 0 and ready_o stays low.
- R9: With los_i high in any phase other than 0, the next edge moves the phase to 0 and restarts the reset pattern at its first burst cycle.
- R10: A COMINIT in the last cycle of the retry interval wins over the retry expiry.
- R11: A COMWAKE in the last cycle of the wake timeout wins over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | 1 | Loss of signal; restarts the exchange |
| cominit_det_i | input | 1 | Detector saw the device's COMINIT |
| comwake_det_i | input | 1 | Detector saw the device's COMWAKE |
| tx_burst_o | output | 1 | 1 = send ALIGN burst, 0 = electrical idle |
| ready_o | output | 1 | Exchange complete; link may carry traffic |
| phase_o | output | 3 | Current phase code (see R1) |

## Verification
The bench builds the block with 4-cycle bursts, a 12-cycle reset gap, a 4-cycle wake gap, a 20-cycle retry interval and a 30-cycle wake timeout. With these lengths, a whole reset pattern is 96 cycles, so every burst edge and gap edge can be checked cycle by cycle. The short windows also let the bench place detector pulses on the first and last cycle of each wait and let both timeouts expire many times within one run. Loss of signal is applied in the middle of the wake signal and while ready, to check that the reset pattern restarts from a clean state.

// File: rtl/oob_pkg.sv
package oob_pkg;

  typedef enum logic [2:0] {
    PH_RESET_TX  = 3'd0,
    PH_WAIT_INIT = 3'd1,
    PH_WAKE_TX   = 3'd2,
    PH_WAIT_WAKE = 3'd3,
    PH_READY     = 3'd4
  } oob_phase_e;

endpackage

// File: rtl/oob_burst_gen.sv
module oob_burst_gen #(
  parameter int BURST_CYC  = 16,
  parameter int LONG_GAP   = 48,
  parameter int SHORT_GAP  = 16,
  parameter int NUM_BURSTS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic short_sel,
  output logic tx_on,
  output logic done
);

  localparam int MAXLEN_A = (BURST_CYC > LONG_GAP) ? BURST_CYC : LONG_GAP;
  localparam int MAXLEN   = (MAXLEN_A > SHORT_GAP) ? MAXLEN_A : SHORT_GAP;
  localparam int CW       = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam int IW       = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1;
  localparam logic [CW-1:0] BURST_LAST = CW'(BURST_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_GAP - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_GAP - 1);
  localparam logic [IW-1:0] IDX_LAST   = IW'(NUM_BURSTS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          gap_q, gap_d;
  logic [CW-1:0] seg_last;
  logic          seg_end;
  logic          last_burst;

  always_comb begin
    if (gap_q) seg_last = short_sel ? SHORT_LAST : LONG_LAST;
    else       seg_last = BURST_LAST;
  end

  assign seg_end    = (cnt_q == seg_last);
  assign last_burst = (idx_q == IDX_LAST);
  assign tx_on      = en && !gap_q;
  assign done       = en && gap_q && seg_end && last_burst;

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    gap_d = gap_q;
    if (seg_end) begin
      cnt_d = '0;
      gap_d = !gap_q;
      if (gap_q) idx_d = last_burst ? '0 : idx_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
      gap_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      idx_q <= '0;
      gap_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      gap_q <= gap_d;
    end
  end

endmodule

// File: rtl/oob_wait_timer.sv
module oob_wait_timer #(
  parameter int RETRY_CYC   = 200,
  parameter int WAKE_TO_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic wake_sel,
  output logic expired
);

  localparam int MAXW = (RETRY_CYC > WAKE_TO_CYC) ? RETRY_CYC : WAKE_TO_CYC;
  localparam int TW   = (MAXW > 1) ? $clog2(MAXW) : 1;
  localparam logic [TW-1:0] RETRY_LAST = TW'(RETRY_CYC - 1);
  localparam logic [TW-1:0] WAKE_LAST  = TW'(WAKE_TO_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] lim;

  assign lim     = wake_sel ? WAKE_LAST : RETRY_LAST;
  assign expired = en && (cnt_q == lim);

  always_comb begin
    cnt_d = expired ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/oob_seq_fsm.sv
module oob_seq_fsm
  import oob_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       los,
  input  logic       cominit,
  input  logic       comwake,
  input  logic       tx_done,
  input  logic       tmr_expired,
  output oob_phase_e phase,
  output logic       phase_change
);

  oob_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (los && ph_q != PH_RESET_TX) begin
      ph_d = PH_RESET_TX;
    end else begin
      unique case (ph_q)
        PH_RESET_TX:  if (tx_done) ph_d = PH_WAIT_INIT;
        PH_WAIT_INIT: begin
          if (cominit)          ph_d = PH_WAKE_TX;
          else if (tmr_expired) ph_d = PH_RESET_TX;
        end
        PH_WAKE_TX:   if (tx_done) ph_d = PH_WAIT_WAKE;
        PH_WAIT_WAKE: begin
          if (comwake)          ph_d = PH_READY;
          else if (tmr_expired) ph_d = PH_RESET_TX;
        end
        PH_READY:     ph_d = PH_READY;
        default:      ph_d = PH_RESET_TX;
      endcase
    end
  end

  assign phase        = ph_q;
  assign phase_change = (ph_d != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_RESET_TX;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/oob_host_init.sv
module oob_host_init
  import oob_pkg::*;
#(
  parameter int BURST_CYC     = 16,
  parameter int RESET_GAP_CYC = 48,
  parameter int WAKE_GAP_CYC  = 16,
  parameter int NUM_BURSTS    = 6,
  parameter int RETRY_CYC     = 200,
  parameter int WAKE_TO_CYC   = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       los_i,
  input  logic       cominit_det_i,
  input  logic       comwake_det_i,
  output logic       tx_burst_o,
  output logic       ready_o,
  output logic [2:0] phase_o
);

  oob_phase_e phase;
  logic       phase_change;
  logic       gen_en, gen_done, gen_tx;
  logic       tmr_en, tmr_expired;

  assign gen_en = (phase == PH_RESET_TX) || (phase == PH_WAKE_TX);
  assign tmr_en = (phase == PH_WAIT_INIT) || (phase == PH_WAIT_WAKE);

  oob_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .los          (los_i),
    .cominit      (cominit_det_i),
    .comwake      (comwake_det_i),
    .tx_done      (gen_done),
    .tmr_expired  (tmr_expired),
    .phase        (phase),
    .phase_change (phase_change)
  );

  oob_burst_gen #(
    .BURST_CYC  (BURST_CYC),
    .LONG_GAP   (RESET_GAP_CYC),
    .SHORT_GAP  (WAKE_GAP_CYC),
    .NUM_BURSTS (NUM_BURSTS)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (phase_change),
    .en        (gen_en),
    .short_sel (phase == PH_WAKE_TX),
    .tx_on     (gen_tx),
    .done      (gen_done)
  );

  oob_wait_timer #(
    .RETRY_CYC   (RETRY_CYC),
    .WAKE_TO_CYC (WAKE_TO_CYC)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (phase_change),
    .en       (tmr_en),
    .wake_sel (phase == PH_WAIT_WAKE),
    .expired  (tmr_expired)
  );

  assign tx_burst_o = gen_tx;
  assign ready_o    = (phase == PH_READY);
  assign phase_o    = phase;

endmodule

// File: rtl/oob_host_init_chk.sv
module oob_host_init_chk #(
  parameter int BURST_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       los_i,
  input logic       cominit_det_i,
  input logic       comwake_det_i,
  input logic       tx_burst_o,
  input logic       ready_o,
  input logic [2:0] phase_o
);

  logic [31:0] run_q, run_cur;
  logic [2:0]  prev_q;

  assign run_cur = tx_burst_o ? ((phase_o == prev_q) ? run_q + 32'd1 : 32'd1) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      prev_q <= 3'd0;
    end else begin
      run_q  <= run_cur;
      prev_q <= phase_o;
    end
  end

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cur <= 32'(BURST_CYC));

  // R3
  wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 || phase_o == 3'd3) |-> !tx_burst_o);

  // R5
  init_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && cominit_det_i && !los_i) |=> (phase_o == 3'd2 && tx_burst_o));

  // R6
  reset_tx_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0) |=> (phase_o == 3'd0 || phase_o == 3'd1));

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(phase_o) == 3'd3 && $past(comwake_det_i)));

  // R9
  los_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los_i && phase_o != 3'd0) |=> (phase_o == 3'd0 && tx_burst_o && !ready_o));

endmodule

bind oob_host_init oob_host_init_chk #(.BURST_CYC(BURST_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .los_i         (los_i),
  .cominit_det_i (cominit_det_i),
  .comwake_det_i (comwake_det_i),
  .tx_burst_o    (tx_burst_o),
  .ready_o       (ready_o),
  .phase_o       (phase_o)
);

// File: tb/sim_oob_host_init.sv
`timescale 1ns/1ps
module sim_oob_host_init;

  localparam int B   = 4;
  localparam int RG  = 12;
  localparam int WG  = 4;
  localparam int NB  = 6;
  localparam int RTY = 20;
  localparam int WTO = 30;

  // table: {COMINIT offset in wait, COMWAKE offset in wait (>= WTO means never)}
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{
    '{0, 0}, '{5, 3}, '{RTY-1, WTO-1}, '{7, WTO}, '{3, 100}, '{12, 17}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic los_i, cominit_det_i, comwake_det_i;
  logic tx_burst_o, ready_o;
  logic [2:0] phase_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  oob_host_init #(
    .BURST_CYC(B), .RESET_GAP_CYC(RG), .WAKE_GAP_CYC(WG),
    .NUM_BURSTS(NB), .RETRY_CYC(RTY), .WAKE_TO_CYC(WTO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .los_i(los_i),
    .cominit_det_i(cominit_det_i), .comwake_det_i(comwake_det_i),
    .tx_burst_o(tx_burst_o), .ready_o(ready_o), .phase_o(phase_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // walk a full signal from its first visible cycle; counts one check
  task automatic chk_pattern(input int gap, input int ph, input string req);
    int bad = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int i = 0; i < NB; i++) begin
      for (int c = 0; c < B + gap; c++) begin
        int e_tx = (c < B) ? 1 : 0;
        if (tx_burst_o !== e_tx[0] || phase_o != ph[2:0]) begin
          if (bad == 0) begin
            first_act = {phase_o, tx_burst_o};
            first_exp = {ph[2:0], e_tx[0]};
          end
          bad++;
        end
        tick();
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s pattern actual={phase,tx}=%0d expected=%0d (%0d bad cycles)",
               req, first_act, first_exp, bad);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    los_i = 1'b0; cominit_det_i = 1'b0; comwake_det_i = 1'b0;
    tick(); tick();
    chk("R1 phase in reset", phase_o, 0);
    chk("R1 ready in reset", ready_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic pulse_init();
    cominit_det_i = 1'b1; tick(); cominit_det_i = 1'b0;
  endtask

  task automatic pulse_wake();
    comwake_det_i = 1'b1; tick(); comwake_det_i = 1'b0;
  endtask

  task automatic to_wait_wake();
    do_reset();
    chk_pattern(RG, 0, "R2");
    pulse_init();
    chk_pattern(WG, 2, "R5");
  endtask

  always @(posedge clk) cyc++;

  initial begin : watchdog
    wait (cyc > 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    // table walk
    for (int v = 0; v < NV; v++) begin
      int ioff = VEC[v][0];
      int woff = VEC[v][1];
      do_reset();
      chk_pattern(RG, 0, "R2");
      chk("R3 wait-init phase", phase_o, 1);
      for (int k = 0; k < ioff; k++) begin
        chk("R3 idle while waiting", tx_burst_o, 0);
        tick();
      end
      pulse_init();
      chk("R5/R10 cominit accepted", phase_o, 2);
      chk_pattern(WG, 2, "R5");
      chk("R5 wait-wake phase", phase_o, 3);
      if (woff < WTO) begin
        for (int k = 0; k < woff; k++) tick();
        pulse_wake();
        chk("R7/R11 phase ready", phase_o, 4);
        chk("R7 ready high", ready_o, 1);
        chk("R7 tx idle when ready", tx_burst_o, 0);
      end else begin
        for (int k = 0; k < WTO - 1; k++) tick();
        chk("R8 still waiting", phase_o, 3);
        tick();
        chk("R8 timeout phase", phase_o, 0);
        chk("R8 ready low", ready_o, 0);
      end
    end

    // R4: retry after silence, full pattern repeated
    do_reset();
    chk_pattern(RG, 0, "R2");
    for (int k = 0; k < RTY - 1; k++) tick();
    chk("R4 before retry", phase_o, 1);
    tick();
    chk("R4 retry phase", phase_o, 0);
    chk_pattern(RG, 0, "R4 repeat");
    chk("R4 back to wait", phase_o, 1);

    // R6: detector pulses during the reset signal
    do_reset();
    tick(); tick();
    cominit_det_i = 1'b1; comwake_det_i = 1'b1;
    tick();
    cominit_det_i = 1'b0; comwake_det_i = 1'b0;
    chk("R6 phase kept in reset tx", phase_o, 0);
    chk("R6 burst kept", tx_burst_o, 1);
    tick();
    chk("R6 gap on time", tx_burst_o, 0);

    // R6: COMINIT during wait-wake, pulses while ready
    to_wait_wake();
    pulse_init();
    chk("R6 cominit ignored in wait-wake", phase_o, 3);
    pulse_wake();
    chk("R7 ready", ready_o, 1);
    pulse_init();
    pulse_wake();
    chk("R6 ready kept", phase_o, 4);

    // R9: loss of signal while ready
    los_i = 1'b1; tick(); los_i = 1'b0;
    chk("R9 los from ready", phase_o, 0);
    chk("R9 ready dropped", ready_o, 0);
    chk_pattern(RG, 0, "R9 restart");

    // R9: loss of signal in the middle of the wake signal
    do_reset();
    chk_pattern(RG, 0, "R2");
    pulse_init();
    for (int k = 0; k < B + 1; k++) tick();
    los_i = 1'b1; tick(); los_i = 1'b0;
    chk("R9 los from wake tx", phase_o, 0);
    chk_pattern(RG, 0, "R9 clean restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule